// File: doc/BRIEF.md
# Element-Addressed Register File

This block is a 128-entry integer register file, 64 bits per register, that software-style vector loops reach by element rather than by whole register. A port names a base register, an element index and a two-bit width code. The block treats the whole file as one little-endian byte array, so element N of a given width sits N element-widths above the start of the base register. Elements run upward through consecutive registers once the index passes the end of one register.

The file has one combinational read port and one clocked write port. Each write carries a predicate bit. The write drives per-byte write enables built from the width code, the start lane and the predicate, so a narrow element lands in place without a read-modify-write of the register. Addresses past the last register are flagged on either port. Such a write is dropped and such a read returns zero.

Top module: `elrf_top`

## Requirements
- R1: After synchronous reset every byte of the file reads as zero.
- R2: The width code selects the element size: 2'b00 is 64 bits, 2'b01 is 32 bits, 2'b10 is 16 bits and 2'b11 is 8 bits. A read returns the element zero-extended to 64 bits.
- R3: The element's byte address is base*8 + index*(element bytes). Bits above the lowest three pick the register and the lowest three pick the starting byte lane, so an index beyond one register continues into the next.
- R4: Bytes are packed little-endian with LSB0 element numbering: element 0 occupies the least significant bytes of the base register.
- R5: A write narrower than 64 bits changes only the bytes of its own element. The other bytes of that register keep their values.
- R6: A write whose predicate bit is 0 changes no byte of the file.
- R7: A 64-bit write with the predicate bit set replaces all eight bytes of the register.
- R8: A write whose byte address lies beyond register 127 changes nothing, and wr_oor is 1 while it is presented. An in-range address gives wr_oor = 0.
- R9: A read whose byte address lies beyond register 127 returns zero with rd_oor = 1. An in-range address gives rd_oor = 0.
- R10: A read of bytes that are being written in the same cycle returns the old contents. The new contents are visible from the next cycle.
- R11: Bits of wr_data above the element width have no effect on the file.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the file |
| rd_base | input | 7 | Read base register number |
| rd_idx | input | 10 | Read element index |
| rd_ew | input | 2 | Read width code |
| rd_data | output | 64 | Read element, zero-extended |
| rd_oor | output | 1 | Read address beyond the file |
| wr_base | input | 7 | Write base register number |
| wr_idx | input | 10 | Write element index |
| wr_ew | input | 2 | Write width code |
| wr_data | input | 64 | Write element in the low bits |
| wr_pred | input | 1 | Write predicate, 1 allows the write |
| wr_oor | output | 1 | Write address beyond the file |

## Verification
The state is the byte array, and the read port shows it at once. A wrong lane enable or a bad register decode therefore appears as a corrupted neighbouring byte the first time that location is read. The bench reads back every location it has just written, and it reads whole registers after narrow writes, so a fault shows within one or two cycles of the write that caused it. Reads that run concurrently with writes also expose an ordering fault in the same cycle.

// File: rtl/elrf_pkg.sv
package elrf_pkg;

    localparam int RF_REGS   = 128;
    localparam int RF_LANES  = 8;
    localparam int RF_DATA_W = RF_LANES * 8;
    localparam int RF_REG_W  = $clog2(RF_REGS);
    localparam int RF_IDX_W  = 10;
    localparam int RF_LANE_W = $clog2(RF_LANES);
    localparam int RF_ADDR_W = ((RF_IDX_W > RF_REG_W) ? RF_IDX_W : RF_REG_W) + RF_LANE_W + 1;

    typedef enum logic [1:0] {
        EW_D64 = 2'b00,
        EW_W32 = 2'b01,
        EW_H16 = 2'b10,
        EW_B8  = 2'b11
    } elw_e;

    typedef struct packed {
        logic [RF_REG_W-1:0]  reg_sel;
        logic [RF_LANE_W-1:0] lane;
        logic                 in_range;
    } elem_loc_t;

    // log2 of element bytes
    function automatic logic [1:0] elw_shift(input elw_e ew);
        return 2'd3 - ew;
    endfunction

    function automatic logic [RF_LANE_W:0] elw_bytes(input elw_e ew);
        return (RF_LANE_W+1)'(RF_LANES >> ew);
    endfunction

    function automatic logic [RF_DATA_W-1:0] elw_mask(input elw_e ew);
        logic [RF_DATA_W-1:0] m;
        case (ew)
            EW_W32:  m = {{(RF_DATA_W-32){1'b0}}, {32{1'b1}}};
            EW_H16:  m = {{(RF_DATA_W-16){1'b0}}, {16{1'b1}}};
            EW_B8:   m = {{(RF_DATA_W-8){1'b0}}, {8{1'b1}}};
            default: m = {RF_DATA_W{1'b1}};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/elrf_addr_gen.sv
module elrf_addr_gen
    import elrf_pkg::*;
(
    input  logic [RF_REG_W-1:0] base,
    input  logic [RF_IDX_W-1:0] idx,
    input  elw_e                ew,
    output elem_loc_t           loc
);
    logic [RF_ADDR_W-1:0] base_byte;
    logic [RF_ADDR_W-1:0] off_byte;
    logic [RF_ADDR_W-1:0] abs_byte;

    always_comb begin
        base_byte = RF_ADDR_W'({base, {RF_LANE_W{1'b0}}});
        off_byte  = RF_ADDR_W'(idx) << elw_shift(ew);
        abs_byte  = base_byte + off_byte;
        loc.lane     = abs_byte[RF_LANE_W-1:0];
        loc.reg_sel  = abs_byte[RF_LANE_W +: RF_REG_W];
        loc.in_range = (abs_byte >> RF_LANE_W) < RF_ADDR_W'(RF_REGS);
    end
endmodule

// File: rtl/elrf_lane_mask.sv
module elrf_lane_mask
    import elrf_pkg::*;
(
    input  elem_loc_t             loc,
    input  elw_e                  ew,
    input  logic                  pred,
    input  logic [RF_DATA_W-1:0]  elem,
    output logic [RF_LANES-1:0]   byte_en,
    output logic [RF_DATA_W-1:0]  lane_data
);
    logic [RF_LANE_W:0] nbytes;
    logic [RF_LANE_W:0] lo;

    assign nbytes = elw_bytes(ew);
    assign lo     = {1'b0, loc.lane};

    genvar g;
    generate
        for (g = 0; g < RF_LANES; g++) begin : g_en
            assign byte_en[g] = pred && loc.in_range
                             && ((RF_LANE_W+1)'(g) >= lo)
                             && ((RF_LANE_W+1)'(g) < lo + nbytes);
        end
    endgenerate

    assign lane_data = (elem & elw_mask(ew)) << {loc.lane, 3'b000};
endmodule

// File: rtl/elrf_storage.sv
module elrf_storage
    import elrf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [RF_REG_W-1:0]  wr_reg,
    input  logic [RF_LANES-1:0]  wr_be,
    input  logic [RF_DATA_W-1:0] wr_word,
    input  logic [RF_REG_W-1:0]  rd_reg,
    output logic [RF_DATA_W-1:0] rd_word
);
    genvar g;
    generate
        for (g = 0; g < RF_LANES; g++) begin : g_lane
            logic [7:0] bank [RF_REGS];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int r = 0; r < RF_REGS; r++) bank[r] <= 8'h00;
                end else if (wr_be[g]) begin
                    bank[wr_reg] <= wr_word[g*8 +: 8];
                end
            end

            assign rd_word[g*8 +: 8] = bank[rd_reg];
        end
    endgenerate
endmodule

// File: rtl/elrf_read_align.sv
module elrf_read_align
    import elrf_pkg::*;
(
    input  elem_loc_t             loc,
    input  elw_e                  ew,
    input  logic [RF_DATA_W-1:0]  word,
    output logic [RF_DATA_W-1:0]  elem
);
    logic [RF_DATA_W-1:0] shifted;

    always_comb begin
        shifted = word >> {loc.lane, 3'b000};
        elem    = loc.in_range ? (shifted & elw_mask(ew)) : '0;
    end
endmodule

// File: rtl/elrf_top.sv
module elrf_top
    import elrf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [RF_REG_W-1:0]  rd_base,
    input  logic [RF_IDX_W-1:0]  rd_idx,
    input  logic [1:0]           rd_ew,
    output logic [RF_DATA_W-1:0] rd_data,
    output logic                 rd_oor,
    input  logic [RF_REG_W-1:0]  wr_base,
    input  logic [RF_IDX_W-1:0]  wr_idx,
    input  logic [1:0]           wr_ew,
    input  logic [RF_DATA_W-1:0] wr_data,
    input  logic                 wr_pred,
    output logic                 wr_oor
);
    elem_loc_t            rloc, wloc;
    logic [RF_LANES-1:0]  be;
    logic [RF_DATA_W-1:0] wword, rword;

    elrf_addr_gen u_rd_addr (.base(rd_base), .idx(rd_idx), .ew(elw_e'(rd_ew)), .loc(rloc));
    elrf_addr_gen u_wr_addr (.base(wr_base), .idx(wr_idx), .ew(elw_e'(wr_ew)), .loc(wloc));

    elrf_lane_mask u_mask (
        .loc(wloc), .ew(elw_e'(wr_ew)), .pred(wr_pred), .elem(wr_data),
        .byte_en(be), .lane_data(wword)
    );

    elrf_storage u_store (
        .clk(clk), .rst(rst),
        .wr_reg(wloc.reg_sel), .wr_be(be), .wr_word(wword),
        .rd_reg(rloc.reg_sel), .rd_word(rword)
    );

    elrf_read_align u_align (.loc(rloc), .ew(elw_e'(rd_ew)), .word(rword), .elem(rd_data));

    assign rd_oor = !rloc.in_range;
    assign wr_oor = !wloc.in_range;
endmodule

// File: rtl/elrf_checker.sv
module elrf_checker
    import elrf_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [RF_REG_W-1:0]  rd_base,
    input logic [RF_IDX_W-1:0]  rd_idx,
    input logic [1:0]           rd_ew,
    input logic [RF_DATA_W-1:0] rd_data,
    input logic                 rd_oor,
    input logic [RF_IDX_W-1:0]  wr_idx,
    input logic                 wr_pred,
    input logic                 wr_oor
);
    p_zero_on_oor_r9: assert property (@(posedge clk) disable iff (rst)
        rd_oor |-> rd_data == '0);

    p_idx0_in_range_r9: assert property (@(posedge clk) disable iff (rst)
        rd_idx == '0 |-> !rd_oor);

    p_idx0_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        wr_idx == '0 |-> !wr_oor);

    p_byte_zext_r2: assert property (@(posedge clk) disable iff (rst)
        rd_ew == 2'b11 |-> rd_data[RF_DATA_W-1:8] == '0);

    p_half_zext_r2: assert property (@(posedge clk) disable iff (rst)
        rd_ew == 2'b10 |-> rd_data[RF_DATA_W-1:16] == '0);

    p_word_zext_r2: assert property (@(posedge clk) disable iff (rst)
        rd_ew == 2'b01 |-> rd_data[RF_DATA_W-1:32] == '0);

    p_masked_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_pred |=> (!($stable(rd_base) && $stable(rd_idx) && $stable(rd_ew))
                      || $stable(rd_data)));
endmodule

bind elrf_top elrf_checker u_chk (
    .clk(clk), .rst(rst), .rd_base(rd_base), .rd_idx(rd_idx), .rd_ew(rd_ew),
    .rd_data(rd_data), .rd_oor(rd_oor), .wr_idx(wr_idx), .wr_pred(wr_pred),
    .wr_oor(wr_oor)
);

// File: tb/tb_elrf_top.sv
module tb_elrf_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [6:0]  rd_base, wr_base;
    logic [9:0]  rd_idx, wr_idx;
    logic [1:0]  rd_ew, wr_ew;
    logic [63:0] rd_data, wr_data;
    logic        rd_oor, wr_oor, wr_pred;

    int n_tests = 0;
    int n_fail  = 0;
    byte unsigned model [1024];

    always #5 clk = ~clk;

    elrf_top dut (
        .clk(clk), .rst(rst),
        .rd_base(rd_base), .rd_idx(rd_idx), .rd_ew(rd_ew), .rd_data(rd_data), .rd_oor(rd_oor),
        .wr_base(wr_base), .wr_idx(wr_idx), .wr_ew(wr_ew), .wr_data(wr_data),
        .wr_pred(wr_pred), .wr_oor(wr_oor)
    );

    function automatic int nb(input logic [1:0] ew);
        return 8 >> ew;
    endfunction

    function automatic int baddr(input logic [6:0] b, input logic [9:0] i, input logic [1:0] ew);
        return int'(b) * 8 + int'(i) * nb(ew);
    endfunction

    function automatic logic [63:0] model_read(input logic [6:0] b, input logic [9:0] i,
                                               input logic [1:0] ew);
        logic [63:0] v = '0;
        int a = baddr(b, i, ew);
        if (a >= 1024) return '0;
        for (int k = 0; k < nb(ew); k++) v[k*8 +: 8] = model[a+k];
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: present read and write, check combinational outputs, then commit write
    task automatic cyc(input string req,
                       input logic [6:0] rb, input logic [9:0] ri, input logic [1:0] re,
                       input logic [6:0] wb, input logic [9:0] wi, input logic [1:0] we,
                       input logic [63:0] wd, input logic wp);
        int a;
        rd_base = rb; rd_idx = ri; rd_ew = re;
        wr_base = wb; wr_idx = wi; wr_ew = we; wr_data = wd; wr_pred = wp;
        #3;
        check(req, rd_data, model_read(rb, ri, re));
        check(req, {63'd0, rd_oor}, {63'd0, baddr(rb, ri, re) >= 1024});
        check(req, {63'd0, wr_oor}, {63'd0, baddr(wb, wi, we) >= 1024});
        @(posedge clk);
        a = baddr(wb, wi, we);
        if (wp && a < 1024)
            for (int k = 0; k < nb(we); k++) model[a+k] = wd[k*8 +: 8];
        #1;
    endtask

    task automatic rd(input string req, input logic [6:0] b, input logic [9:0] i, input logic [1:0] e);
        cyc(req, b, i, e, 7'd0, 10'd0, 2'b00, 64'd0, 1'b0);
    endtask

    task automatic wr(input string req, input logic [6:0] b, input logic [9:0] i, input logic [1:0] e,
                      input logic [63:0] d, input logic p);
        cyc(req, b, i, e, b, i, e, d, p);
    endtask

    task automatic expect_rd(input string req, input logic [6:0] b, input logic [9:0] i,
                             input logic [1:0] e, input logic [63:0] exp);
        rd_base = b; rd_idx = i; rd_ew = e; wr_pred = 1'b0;
        #3;
        check(req, rd_data, exp);
        @(posedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 1024; k++) model[k] = 8'h00;
        rst = 1'b1;
        rd_base = '0; rd_idx = '0; rd_ew = '0;
        wr_base = '0; wr_idx = '0; wr_ew = '0; wr_data = '0; wr_pred = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset contents
        rd("R1", 7'd0, 10'd0, 2'b00);
        rd("R1", 7'd127, 10'd0, 2'b00);
        expect_rd("R1", 7'd64, 10'd0, 2'b00, 64'd0);

        // R7 full 64-bit write
        wr("R7", 7'd5, 10'd0, 2'b00, 64'hA1A2_A3A4_A5A6_A7A8, 1'b1);
        expect_rd("R7", 7'd5, 10'd0, 2'b00, 64'hA1A2_A3A4_A5A6_A7A8);

        // R5 byte write leaves neighbours
        wr("R5", 7'd5, 10'd3, 2'b11, 64'h0000_0000_0000_003C, 1'b1);
        expect_rd("R5", 7'd5, 10'd0, 2'b00, 64'hA1A2_A3A4_3CA6_A7A8);
        expect_rd("R2", 7'd5, 10'd3, 2'b11, 64'h3C);

        // R6 predicate off
        wr("R6", 7'd5, 10'd0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        expect_rd("R6", 7'd5, 10'd0, 2'b00, 64'hA1A2_A3A4_3CA6_A7A8);

        // R3 index crosses into next register: base 10, idx 5, 16-bit -> reg 11 lanes 2..3
        wr("R3", 7'd10, 10'd5, 2'b10, 64'h0000_0000_0000_BEEF, 1'b1);
        expect_rd("R3", 7'd11, 10'd0, 2'b00, 64'h0000_0000_BEEF_0000);
        expect_rd("R3", 7'd11, 10'd1, 2'b10, 64'hBEEF);

        // R11 upper bits of wr_data ignored
        wr("R11", 7'd40, 10'd1, 2'b01, 64'hDEAD_DEAD_1234_5678, 1'b1);
        expect_rd("R11", 7'd40, 10'd0, 2'b00, 64'h1234_5678_0000_0000);

        // R4 little-endian LSB0 packing
        wr("R4", 7'd30, 10'd0, 2'b00, 64'h8877_6655_4433_2211, 1'b1);
        expect_rd("R4", 7'd30, 10'd0, 2'b11, 64'h11);
        expect_rd("R4", 7'd30, 10'd3, 2'b10, 64'h8877);
        expect_rd("R4", 7'd30, 10'd1, 2'b01, 64'h8877_6655);

        // R8 / R9 beyond the file
        wr("R8", 7'd127, 10'd1, 2'b00, 64'h5555_5555_5555_5555, 1'b1);
        wr("R8", 7'd127, 10'd7, 2'b11, 64'h77, 1'b1);
        expect_rd("R8", 7'd127, 10'd0, 2'b00, 64'h7700_0000_0000_0000);
        rd("R9", 7'd127, 10'd8, 2'b11);
        rd("R9", 7'd100, 10'd200, 2'b00);

        // R10 read during write sees old, then new
        cyc("R10", 7'd20, 10'd0, 2'b00, 7'd20, 10'd0, 2'b00, 64'h0102_0304_0506_0708, 1'b1);
        expect_rd("R10", 7'd20, 10'd0, 2'b00, 64'h0102_0304_0506_0708);

        // mixed traffic against the model (R2, R3, R5, R6, R8, R9)
        for (int n = 0; n < 3000; n++) begin
            logic [9:0] ri = (n % 5 == 0) ? 10'($urandom) : 10'($urandom_range(0, 40));
            logic [9:0] wi = (n % 7 == 0) ? 10'($urandom) : 10'($urandom_range(0, 40));
            cyc("R2 R5 R6 R8 R9 mixed",
                7'($urandom), ri, 2'($urandom),
                7'($urandom), wi, 2'($urandom),
                {$urandom, $urandom}, 1'($urandom_range(0, 3) != 0));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule